// File: doc/BRIEF.md
# Serial Memory Command Sequencer

This block sits between a serial byte front end and a 512-entry, byte-wide storage array. Bytes arrive one at a time with a valid strobe. The block parses them into instructions: pointer write and pointer read, read, write, erase, erase-all, write-all, and a one-shot protection override. It then either returns bytes for shifting out or starts a self-timed modify cycle on the array. A programmable counter stands in for the cell programming time. Each write first runs a clear phase and then a program phase. A plain erase runs only the clear phase.

Two conditions gate every modifying instruction. The first is a write-permit level supplied by an external lock manager. The second is a memory pointer: every address at or above the pointer is protected. An override instruction lifts that protection for the next instruction only. The block can report its ready/busy state on the serial data line. Any byte that arrives while a cycle is running is dropped.

Top module: `memseq_top`

## Requirements
- R1: After reset, rd_valid is low, the pointer reads back as 0x00 then 0x00, and every array location holds 0xFF.
- R2: Pointer write (0xC4, address high byte, address low byte) loads the pointer with the low 9 bits of the 16-bit address, but only while write_permit is high. Pointer read (0xCA) returns the pointer zero-extended to 16 bits as two bytes, high byte first. The first byte appears in the cycle after the opcode is accepted and the second byte in the cycle after that.
- R3: Read (0xC9, high, low) presents the addressed byte on rd_data with rd_valid high in the cycle after the low byte is accepted. The address wraps modulo 512.
- R4: Write (0xC1, high, low, data) on a permitted address holds busy for 2*CYC_LEN cycles, starting in the cycle after the data byte. After that window the location holds the data byte.
- R5: Erase (0xC0, high, low) on a permitted address holds busy for CYC_LEN cycles, after which the location holds 0xFF.
- R6: Two consecutive 0x89 bytes set every location to 0xFF with a busy window of CYC_LEN cycles. The sequence 0x89, 0xC3, data sets every location to the data byte with a busy window of 2*CYC_LEN cycles. Any other byte after 0x89 abandons the sequence.
- R7: When busy_report_en is high, dout_oe is high and dout is 0 while a cycle runs and 1 otherwise. When busy_report_en is low, dout_oe is low.
- R8: While write_permit is low, write, erase, erase-all, write-all and pointer write are discarded: no busy window and no change to the array or the pointer.
- R9: Write or erase to an address greater than or equal to the pointer is discarded unless an override (0x83) came earlier. Erase-all and write-all always require the override. The override is consumed by the next completed or abandoned instruction.
- R10: Bytes that arrive while a cycle is running are dropped entirely: they produce no read output and do not set the override.
- R11: Unrecognised opcode bytes are ignored and leave the array and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | byte_in carries a received byte this cycle |
| byte_in | input | 8 | Received instruction, address or data byte |
| write_permit | input | 1 | High when the lock manager allows modification |
| busy_report_en | input | 1 | Enables ready/busy reporting on dout |
| rd_valid | output | 1 | rd_data holds a byte to shift out |
| rd_data | output | 8 | Read data or pointer byte |
| dout | output | 1 | Ready (1) / busy (0) level |
| dout_oe | output | 1 | Drive enable for dout |

## Verification
The hardest situation to reach is a byte arriving while a cycle is running, because it is the only way to show that the sequencer ignores traffic rather than queueing it. The bench issues a write and then, inside the 2*CYC_LEN window, sends a complete read instruction. It checks that no read byte appears and that a later read returns the new data. The protection override is also consumed in non-obvious ways: by an abandoned 0x89 sequence and by discarded commands. The stimulus therefore chains override, abandon and retry sequences and checks the array contents afterwards.

// File: rtl/memseq_pkg.sv
// Package memseq_pkg
// Shared opcodes, parser states, job description and timer phases for the
// serial memory command sequencer. Assumes a byte-wide instruction stream.
package memseq_pkg;

    localparam logic [7:0] OPC_PTR_WR   = 8'hC4;
    localparam logic [7:0] OPC_PTR_RD   = 8'hCA;
    localparam logic [7:0] OPC_READ     = 8'hC9;
    localparam logic [7:0] OPC_WRITE    = 8'hC1;
    localparam logic [7:0] OPC_ERASE    = 8'hC0;
    localparam logic [7:0] OPC_ALL      = 8'h89;
    localparam logic [7:0] OPC_WRALL    = 8'hC3;
    localparam logic [7:0] OPC_OVERRIDE = 8'h83;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ADDR_HI,
        PS_ADDR_LO,
        PS_DATA,
        PS_ALL_2ND,
        PS_ALL_DATA
    } parse_e;

    typedef enum logic [1:0] {
        MOD_ERASE,
        MOD_WRITE,
        MOD_ERASE_ALL,
        MOD_WRITE_ALL
    } mod_e;

    typedef struct packed {
        mod_e        kind;
        logic [15:0] addr;
        logic [7:0]  data;
    } job_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_PROGRAM
    } phase_e;

endpackage

// File: rtl/memseq_decode.sv
// Module memseq_decode
// Parses the incoming byte stream into instructions, holds the memory
// pointer and the one-shot override, and decides whether a modifying
// instruction may start. Assumes ADDR_W <= 16; bytes are dropped while busy.
module memseq_decode
    import memseq_pkg::*;
#(
    parameter int ADDR_W = 9
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              busy,
    input  logic              write_permit,
    output logic              job_go,
    output job_t              job,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ptr_rd,
    output logic [ADDR_W-1:0] ptr
);

    parse_e            st_q, st_n;
    logic [7:0]        opc_q, opc_n;
    logic [7:0]        hi_q, hi_n;
    logic [7:0]        lo_q, lo_n;
    logic              ovr_q, ovr_n;
    logic [ADDR_W-1:0] ptr_q, ptr_n;
    logic              accept;
    logic              done;
    logic [15:0]       a_cur16;
    logic [15:0]       a_held16;
    logic [ADDR_W-1:0] a_cur;
    logic [ADDR_W-1:0] a_held;

    // Candidate addresses: one completed by the current byte, one held.
    assign a_cur16  = {hi_q, byte_in};
    assign a_held16 = {hi_q, lo_q};
    assign a_cur    = a_cur16[ADDR_W-1:0];
    assign a_held   = a_held16[ADDR_W-1:0];
    assign accept   = byte_valid && !busy;
    assign rd_addr  = a_cur;
    assign ptr      = ptr_q;

    // Permission for a single-location edit.
    function automatic logic may_edit(input logic [ADDR_W-1:0] a);
        return write_permit && (ovr_q || (a < ptr_q));
    endfunction

    // Next-state and command decode for one accepted byte.
    always_comb begin
        st_n   = st_q;
        opc_n  = opc_q;
        hi_n   = hi_q;
        lo_n   = lo_q;
        ovr_n  = ovr_q;
        ptr_n  = ptr_q;
        done   = 1'b0;
        job_go = 1'b0;
        job    = '{kind: MOD_ERASE, addr: 16'h0000, data: 8'h00};
        rd_req = 1'b0;
        ptr_rd = 1'b0;
        if (accept) begin
            unique case (st_q)
                PS_IDLE: begin
                    case (byte_in)
                        OPC_PTR_WR, OPC_READ, OPC_WRITE, OPC_ERASE: begin
                            opc_n = byte_in;
                            st_n  = PS_ADDR_HI;
                        end
                        OPC_PTR_RD: begin
                            ptr_rd = 1'b1;
                            done   = 1'b1;
                        end
                        OPC_OVERRIDE: ovr_n = 1'b1;
                        OPC_ALL:      st_n  = PS_ALL_2ND;
                        default: ;
                    endcase
                end
                PS_ADDR_HI: begin
                    hi_n = byte_in;
                    st_n = PS_ADDR_LO;
                end
                PS_ADDR_LO: begin
                    lo_n = byte_in;
                    st_n = PS_IDLE;
                    done = 1'b1;
                    case (opc_q)
                        OPC_PTR_WR: if (write_permit) ptr_n = a_cur;
                        OPC_READ:   rd_req = 1'b1;
                        OPC_ERASE: begin
                            if (may_edit(a_cur)) begin
                                job_go   = 1'b1;
                                job.kind = MOD_ERASE;
                                job.addr = 16'(a_cur);
                            end
                        end
                        default: begin
                            st_n = PS_DATA;
                            done = 1'b0;
                        end
                    endcase
                end
                PS_DATA: begin
                    st_n = PS_IDLE;
                    done = 1'b1;
                    if (may_edit(a_held)) begin
                        job_go   = 1'b1;
                        job.kind = MOD_WRITE;
                        job.addr = 16'(a_held);
                        job.data = byte_in;
                    end
                end
                PS_ALL_2ND: begin
                    if (byte_in == OPC_WRALL) begin
                        st_n = PS_ALL_DATA;
                    end else begin
                        st_n = PS_IDLE;
                        done = 1'b1;
                        if (byte_in == OPC_ALL && write_permit && ovr_q) begin
                            job_go   = 1'b1;
                            job.kind = MOD_ERASE_ALL;
                        end
                    end
                end
                PS_ALL_DATA: begin
                    st_n = PS_IDLE;
                    done = 1'b1;
                    if (write_permit && ovr_q) begin
                        job_go   = 1'b1;
                        job.kind = MOD_WRITE_ALL;
                        job.data = byte_in;
                    end
                end
                default: st_n = PS_IDLE;
            endcase
            if (done) ovr_n = 1'b0;
        end
    end

    // Parser, pointer and override registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_IDLE;
            opc_q <= 8'h00;
            hi_q  <= 8'h00;
            lo_q  <= 8'h00;
            ovr_q <= 1'b0;
            ptr_q <= '0;
        end else begin
            st_q  <= st_n;
            opc_q <= opc_n;
            hi_q  <= hi_n;
            lo_q  <= lo_n;
            ovr_q <= ovr_n;
            ptr_q <= ptr_n;
        end
    end

    // R10: traffic during a cycle leaves the parser state untouched.
    p_frozen_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_valid) |=> ($stable(st_q) && $stable(ptr_q) && $stable(ovr_q)));

    // R9: whole-array jobs only start under an active override.
    p_all_needs_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (job_go && (job.kind == MOD_ERASE_ALL || job.kind == MOD_WRITE_ALL)) |-> ovr_q);

endmodule

// File: rtl/memseq_timer.sv
// Module memseq_timer
// Models the self-timed modify cycle: a clear phase, optionally followed by
// a program phase, each CYC_LEN cycles long. Assumes start only while idle.
module memseq_timer
    import memseq_pkg::*;
#(
    parameter int CYC_LEN = 1000
)
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic two_phase,
    output logic busy,
    output logic clear_end,
    output logic program_end
);

    localparam int CNT_W = $clog2(CYC_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC_LEN - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             both_q;

    assign busy        = (phase_q != PH_IDLE);
    assign clear_end   = (phase_q == PH_CLEAR)   && (cnt_q == '0);
    assign program_end = (phase_q == PH_PROGRAM) && (cnt_q == '0);

    // Phase sequencing and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            both_q  <= 1'b0;
        end else if (start) begin
            phase_q <= PH_CLEAR;
            cnt_q   <= LOAD;
            both_q  <= two_phase;
        end else if (phase_q != PH_IDLE) begin
            if (cnt_q == '0) begin
                if (phase_q == PH_CLEAR && both_q) begin
                    phase_q <= PH_PROGRAM;
                    cnt_q   <= LOAD;
                end else begin
                    phase_q <= PH_IDLE;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R10: a new job never lands on a running cycle.
    p_start_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase_q == PH_IDLE));

    // R4: an accepted job makes the block busy on the next cycle.
    p_start_raises_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R4: programming is always preceded by a completed clear phase.
    p_program_follows_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q == PH_PROGRAM) |-> $past(clear_end));

endmodule

// File: rtl/memseq_store.sv
// Module memseq_store
// Flop-based byte array. Each cell compares itself against the job so
// that whole-array clears and fills finish in one edge. Assumes the job is
// held stable for the duration of the cycle.
module memseq_store
    import memseq_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_end,
    input  logic              program_end,
    input  job_t              job,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);

    logic [7:0]        cells [DEPTH];
    logic              whole;
    logic [ADDR_W-1:0] tgt;

    assign whole   = (job.kind == MOD_ERASE_ALL) || (job.kind == MOD_WRITE_ALL);
    assign tgt     = job.addr[ADDR_W-1:0];
    assign rd_byte = cells[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [7:0] cell_q;
        logic       hit;

        assign hit      = whole || (tgt == ADDR_W'(g));
        assign cells[g] = cell_q;

        // One cell: reset and clear to all ones, program with job data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= 8'hFF;
            end else if (clear_end && hit) begin
                cell_q <= 8'hFF;
            end else if (program_end && hit) begin
                cell_q <= job.data;
            end
        end
    end

    // R6: clear and program completions never coincide.
    p_single_edit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_end, program_end}));

    // R5: a clear leaves the target location at all ones.
    p_cell_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_end |=> (cells[tgt] == 8'hFF));

endmodule

// File: rtl/memseq_top.sv
// Module memseq_top
// Serial memory command sequencer: decoder, cycle timer and byte array,
// with the read/pointer output register and the ready/busy line.
// Assumes pointer reads are separated by at least one idle byte slot.
module memseq_top #(
    parameter int DEPTH   = 512,
    parameter int CYC_LEN = 1000
)
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       write_permit,
    input  logic       busy_report_en,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       dout,
    output logic       dout_oe
);

    import memseq_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);

    logic              busy;
    logic              job_go;
    job_t              job_new;
    job_t              job_q;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              ptr_rd;
    logic [ADDR_W-1:0] ptr;
    logic [15:0]       ptr16;
    logic              clear_end;
    logic              program_end;
    logic [7:0]        rd_byte;
    logic              ptr_lo_q;
    logic              two_phase;

    assign ptr16     = 16'(ptr);
    assign two_phase = (job_new.kind == MOD_WRITE) || (job_new.kind == MOD_WRITE_ALL);
    assign dout      = !busy;
    assign dout_oe   = busy_report_en;

    memseq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid),
        .byte_in      (byte_in),
        .busy         (busy),
        .write_permit (write_permit),
        .job_go       (job_go),
        .job          (job_new),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .ptr_rd       (ptr_rd),
        .ptr          (ptr)
    );

    memseq_timer #(.CYC_LEN(CYC_LEN)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (job_go),
        .two_phase   (two_phase),
        .busy        (busy),
        .clear_end   (clear_end),
        .program_end (program_end)
    );

    memseq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_end   (clear_end),
        .program_end (program_end),
        .job         (job_q),
        .rd_addr     (rd_addr),
        .rd_byte     (rd_byte)
    );

    // Hold the accepted job for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_q <= '{kind: MOD_ERASE, addr: 16'h0000, data: 8'h00};
        end else if (job_go) begin
            job_q <= job_new;
        end
    end

    // Output register for read bytes and the two pointer bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
            ptr_lo_q <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            ptr_lo_q <= 1'b0;
            if (ptr_rd) begin
                rd_valid <= 1'b1;
                rd_data  <= ptr16[15:8];
                ptr_lo_q <= 1'b1;
            end else if (ptr_lo_q) begin
                rd_valid <= 1'b1;
                rd_data  <= ptr16[7:0];
            end else if (rd_req) begin
                rd_valid <= 1'b1;
                rd_data  <= rd_byte;
            end
        end
    end

    // R8: no modify cycle starts without the lock manager's permit.
    p_go_needs_permit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        job_go |-> write_permit);

    // R2: a pointer read yields two consecutive output bytes.
    p_ptr_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd |=> rd_valid ##1 rd_valid);

    // R3: a read answers in the following cycle.
    p_read_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

endmodule

// File: tb/memseq_top_bench.sv
module memseq_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int CYC        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bv = 1'b0;
    logic [7:0] bin = 8'h00;
    logic       permit = 1'b1;
    logic       rpt = 1'b1;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       dout;
    logic       dout_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memseq_top #(.DEPTH(DEPTH), .CYC_LEN(CYC)) u_memseq_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .byte_valid     (bv),
        .byte_in        (bin),
        .write_permit   (permit),
        .busy_report_en (rpt),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .dout           (dout),
        .dout_oe        (dout_oe)
    );

    int    vectors = 0;
    int    errors  = 0;
    string req     = "R1";
    bit    cmp_on  = 1'b0;
    bit    finished = 1'b0;

    // Behavioural reference model state.
    int m_mem [DEPTH];
    int m_st, m_opc, m_hi, m_lo, m_ptr;
    bit m_ovr;
    int m_ph, m_cnt;
    bit m_two;
    int m_kind, m_addr, m_data;
    bit e_rv, m_pend;
    int e_rd;

    task automatic m_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
        m_st = 0; m_opc = 0; m_hi = 0; m_lo = 0; m_ptr = 0; m_ovr = 0;
        m_ph = 0; m_cnt = 0; m_two = 0; m_kind = 0; m_addr = 0; m_data = 0;
        e_rv = 0; e_rd = 0; m_pend = 0;
    endtask

    function automatic bit m_may(int a);
        return permit && (m_ovr || a < m_ptr);
    endfunction

    task automatic m_start(int kind, int a, int d, bit two);
        m_kind = kind; m_addr = a; m_data = d; m_two = two;
        m_ph = 1; m_cnt = CYC;
    endtask

    task automatic m_apply(int val);
        if (m_kind >= 2) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = val;
        end else begin
            m_mem[m_addr] = val;
        end
    endtask

    // Model step on every rising edge; kinds: 0 erase,1 write,2 erase-all,3 write-all.
    always @(posedge clk) begin
        bit was_busy;
        bit done;
        bit nrv;
        int nrd;
        int a;
        if (!rst_n) begin
            m_reset();
        end else begin
            was_busy = (m_ph != 0);
            done = 0;
            nrv = 0;
            nrd = e_rd;
            if (m_pend) begin
                nrv = 1; nrd = m_ptr % 256; m_pend = 0;
            end
            if (was_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_ph == 1) begin
                        m_apply(255);
                        if (m_two) begin m_ph = 2; m_cnt = CYC; end
                        else m_ph = 0;
                    end else begin
                        m_apply(m_data);
                        m_ph = 0;
                    end
                end
            end else if (bv) begin
                case (m_st)
                    0: begin
                        if (bin == 8'hC4 || bin == 8'hC9 || bin == 8'hC1 || bin == 8'hC0) begin
                            m_opc = bin; m_st = 1;
                        end else if (bin == 8'hCA) begin
                            nrv = 1; nrd = m_ptr / 256; m_pend = 1; done = 1;
                        end else if (bin == 8'h83) begin
                            m_ovr = 1;
                        end else if (bin == 8'h89) begin
                            m_st = 4;
                        end
                    end
                    1: begin m_hi = bin; m_st = 2; end
                    2: begin
                        a = (m_hi * 256 + bin) % DEPTH;
                        m_st = 0; done = 1;
                        if (m_opc == 8'hC4) begin
                            if (permit) m_ptr = a;
                        end else if (m_opc == 8'hC9) begin
                            nrv = 1; nrd = m_mem[a];
                        end else if (m_opc == 8'hC0) begin
                            if (m_may(a)) m_start(0, a, 0, 0);
                        end else begin
                            m_lo = bin; m_st = 3; done = 0;
                        end
                    end
                    3: begin
                        a = (m_hi * 256 + m_lo) % DEPTH;
                        m_st = 0; done = 1;
                        if (m_may(a)) m_start(1, a, bin, 1);
                    end
                    4: begin
                        if (bin == 8'hC3) begin
                            m_st = 5;
                        end else begin
                            m_st = 0; done = 1;
                            if (bin == 8'h89 && permit && m_ovr) m_start(2, 0, 0, 0);
                        end
                    end
                    default: begin
                        m_st = 0; done = 1;
                        if (permit && m_ovr) m_start(3, 0, bin, 1);
                    end
                endcase
                if (done) m_ovr = 0;
            end
            e_rv = nrv;
            e_rd = nrd;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        bit bad;
        if (cmp_on && !finished) begin
            bad = 0;
            vectors++;
            if (rd_valid !== e_rv) bad = 1;
            if (e_rv && rd_data !== 8'(e_rd)) bad = 1;
            if (rpt) begin
                if (dout_oe !== 1'b1 || dout !== (m_ph == 0)) bad = 1;
            end else if (dout_oe !== 1'b0) begin
                bad = 1;
            end
            if (bad) begin
                errors++;
                $display("FAIL %s: actual rv=%b rd=%h dout=%b oe=%b expected rv=%b rd=%h dout=%b oe=%b",
                         req, rd_valid, rd_data, dout, dout_oe, e_rv, 8'(e_rd), (m_ph == 0), rpt);
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(int b);
        @(negedge clk);
        bv = 1'b1; bin = 8'(b);
        @(negedge clk);
        bv = 1'b0;
    endtask

    task automatic wait_ready();
        while (m_ph != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int busy_len_start();
        return 0;
    endfunction

    task automatic count_busy(output int n);
        n = 0;
        while (dout == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_at(int hi, int lo, int exp, string tag);
        send(8'hC9); send(hi); send(lo);
        chk(rd_valid === 1'b1 && rd_data === 8'(exp), tag, rd_data, exp);
    endtask

    task automatic read_ptr(int exp, string tag);
        send(8'hCA);
        chk(rd_valid === 1'b1 && rd_data === 8'(exp / 256), tag, rd_data, exp / 256);
        @(negedge clk);
        chk(rd_valid === 1'b1 && rd_data === 8'(exp % 256), tag, rd_data, exp % 256);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit saw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // R1 reset state
        req = "R1";
        chk(rd_valid === 1'b0 && dout === 1'b1, "R1", rd_valid, 0);
        read_ptr(0, "R1");
        read_at(8'h00, 8'h05, 8'hFF, "R1");

        // R2 pointer write and read back, including wrap of high bits
        req = "R2";
        send(8'hC4); send(8'h01); send(8'h00);
        read_ptr(16'h0100, "R2");
        send(8'hC4); send(8'hFE); send(8'h10);
        read_ptr(16'h0010, "R2");
        send(8'hC4); send(8'h01); send(8'h00);

        // R4 write with clear and program phases
        req = "R4";
        send(8'hC1); send(8'h00); send(8'h05); send(8'hA5);
        count_busy(n);
        chk(n == 2 * CYC, "R4", n, 2 * CYC);
        wait_ready();
        read_at(8'h00, 8'h05, 8'hA5, "R4");

        // R3 read address wraps modulo depth
        req = "R3";
        read_at(8'h02, 8'h05, 8'hA5, "R3");
        send(8'hC1); send(8'h02); send(8'h07); send(8'h3C);
        wait_ready();
        read_at(8'h00, 8'h07, 8'h3C, "R3");

        // R5 erase single location
        req = "R5";
        send(8'hC0); send(8'h00); send(8'h05);
        count_busy(n);
        chk(n == CYC, "R5", n, CYC);
        wait_ready();
        read_at(8'h00, 8'h05, 8'hFF, "R5");

        // R9 protection and override
        req = "R9";
        send(8'hC1); send(8'h01); send(8'h50); send(8'h5A);
        count_busy(n);
        chk(n == 0, "R9", n, 0);
        read_at(8'h01, 8'h50, 8'hFF, "R9");
        send(8'h83); send(8'hC1); send(8'h01); send(8'h50); send(8'h5A);
        count_busy(n);
        chk(n == 2 * CYC, "R9", n, 2 * CYC);
        wait_ready();
        read_at(8'h01, 8'h50, 8'h5A, "R9");
        send(8'hC1); send(8'h01); send(8'h50); send(8'h11);
        wait_ready();
        read_at(8'h01, 8'h50, 8'h5A, "R9");

        // R8 locked device discards modifying commands
        req = "R8";
        permit = 1'b0;
        send(8'hC1); send(8'h00); send(8'h20); send(8'h77);
        count_busy(n);
        chk(n == 0, "R8", n, 0);
        read_at(8'h00, 8'h20, 8'hFF, "R8");
        send(8'hC4); send(8'h00); send(8'h10);
        read_ptr(16'h0100, "R8");
        permit = 1'b1;

        // R10 bytes during a busy window are dropped
        req = "R10";
        send(8'hC1); send(8'h00); send(8'h30); send(8'h44);
        saw = 0;
        fork
            begin
                repeat (2 * CYC) begin
                    if (rd_valid) saw = 1;
                    @(negedge clk);
                end
            end
            begin
                send(8'hC9); send(8'h00); send(8'h30);
            end
        join
        chk(saw == 0, "R10", saw, 0);
        wait_ready();
        read_at(8'h00, 8'h30, 8'h44, "R10");

        // R11 unknown opcodes ignored
        req = "R11";
        send(8'h55);
        read_at(8'h00, 8'h30, 8'h44, "R11");
        send(8'h00);
        read_ptr(16'h0100, "R11");

        // R6 whole-array commands
        req = "R6";
        send(8'h89); send(8'h89);
        count_busy(n);
        chk(n == 0, "R6", n, 0);
        read_at(8'h00, 8'h07, 8'h3C, "R6");
        send(8'h83); send(8'h89); send(8'h89);
        count_busy(n);
        chk(n == CYC, "R6", n, CYC);
        wait_ready();
        read_at(8'h00, 8'h07, 8'hFF, "R6");
        read_at(8'h01, 8'h50, 8'hFF, "R6");
        send(8'h83); send(8'h89); send(8'hC3); send(8'hD2);
        count_busy(n);
        chk(n == 2 * CYC, "R6", n, 2 * CYC);
        wait_ready();
        read_at(8'h00, 8'h00, 8'hD2, "R6");
        read_at(8'h01, 8'hFF, 8'hD2, "R6");
        send(8'h83); send(8'h89); send(8'h12);
        send(8'h89); send(8'h89);
        count_busy(n);
        chk(n == 0, "R6", n, 0);
        read_at(8'h00, 8'h00, 8'hD2, "R6");

        // R7 busy reporting disabled leaves the line undriven
        req = "R7";
        rpt = 1'b0;
        send(8'hC0); send(8'h00); send(8'h00);
        chk(dout_oe === 1'b0, "R7", dout_oe, 0);
        wait_ready();
        rpt = 1'b1;
        @(negedge clk);
        chk(dout_oe === 1'b1 && dout === 1'b1, "R7", dout, 1);
        read_at(8'h00, 8'h00, 8'hFF, "R7");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule